// File: doc/BRIEF.md
# SAR Converter Serial Readout Port

This block is the digital readout side of an 18-bit, single-channel successive-approximation converter. The analog core is not modelled. A stub outside the block pulses `conv_done` and presents the finished result on `conv_data`. The serial pins `cnv`, `sdi` and `sck` are sampled on the system clock. A rising edge on `cnv` starts a conversion. At that edge the block chooses one of two port behaviours, and it also decides whether the finished result is announced by a leading start bit.

In select mode the serial output is driven only while the select condition holds, which is `cnv` low or `sdi` low. Once the start bit (if any) and all 18 result bits have gone out, the output is released. In chain mode the block works as one stage of a serial shift chain. After its own 18 bits it passes on, in order, every bit captured from `sdi`, so several converters can share one data line. The tri-state driver is modelled as `sdo` plus an enable `sdo_oe`. `sdo` reads 0 whenever the enable is low.

Each pin is registered once on entry, and a pin edge is acted on at the second rising clock edge after the pin changes. Pin levels described as "before the edge" are the levels registered one clock before the `cnv` edge was seen.

Top module: `sar_serial_port`

## Requirements
- R1: After reset `sdo_oe` is 0, `sdo` is 0 and `conv_busy` is 0.
- R2: A `cnv` rising edge while no conversion runs raises `conv_busy`. A `conv_done` pulse while converting lowers it and makes the result ready. A `conv_done` pulse while idle has no effect.
- R3: The port mode is latched at the `cnv` rising edge from the `sdi` level just before it: 1 selects select mode and 0 selects chain mode. When `sdi` and `cnv` are driven by one signal, chain mode results.
- R4: A `cnv` rising edge during a running conversion is ignored, and the mode and start-bit choice stay as they were.
- R5: In select mode a start bit (value 1) leads the data when `cnv` or `sdi` is low at the clock where `conv_done` is taken. Otherwise the MSB is presented first.
- R6: In chain mode a start bit (value 1) leads the data when `sck` was high just before the `cnv` rising edge.
- R7: Output bits go MSB first, and each falling edge of `sck` advances `sdo` by one bit. In select mode, edges that arrive while deselected do not advance.
- R8: In select mode `sdo_oe` is 1 only while the result is ready, not yet fully shifted out, and `cnv` or `sdi` is low. It drops after the last data bit.
- R9: In chain mode, after the 18 own bits, `sdo` presents the `sdi` levels captured at successive `sck` falling edges, in capture order, and `sdo_oe` stays 1.
- R10: `sdo_oe` is 0 during a conversion. A `cnv` rising edge while a result is being read out abandons the readout.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cnv | input | 1 | Conversion start pin, also a select term in select mode |
| sdi | input | 1 | Mode strap at conversion start, select term or chain data input |
| sck | input | 1 | Serial clock, output advances on its falling edge |
| conv_done | input | 1 | One-cycle pulse from the core stub: result is valid |
| conv_data | input | 18 | Result word from the core stub |
| sdo | output | 1 | Serial data output, 0 when not enabled |
| sdo_oe | output | 1 | Output driver enable |
| conv_busy | output | 1 | High while a conversion is running |

## Verification
A wrong latched mode or start-bit choice does not show up until readout. There it appears as an extra or missing leading 1 on `sdo`, or as the enable following the wrong select rule, in the first cycle after `conv_done`. A wrong shift count or capture path appears at the 18th `sck` falling edge. At that point the select-mode enable fails to drop, or the chain output does not present the first captured `sdi` bit. Comparing both output pins against the model on every clock catches each of these within two clocks of the pin edge that exposes it.

// File: rtl/sar_port_pkg.sv
// Package: shared types for the converter serial port.
// Assumes all pin inputs are synchronous to clk (the bench drives them so).
package sar_port_pkg;

    // Port behaviour latched at conversion start.
    typedef enum logic {
        PORT_CHAIN  = 1'b0,
        PORT_SELECT = 1'b1
    } port_mode_e;

    // Registered copy of the serial pins.
    typedef struct packed {
        logic cnv;
        logic sdi;
        logic sck;
    } pin_view_s;

endpackage

// File: rtl/sar_pin_sampler.sv
// Module: registers the serial pins twice (current and previous view) and
// derives the cnv rising and sck falling events from the two views.
// Assumes pins are synchronous to clk; events are valid for one cycle.
module sar_pin_sampler
    import sar_port_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      cnv,
    input  logic      sdi,
    input  logic      sck,
    output pin_view_s now_o,
    output pin_view_s prev_o,
    output logic      cnv_rise_o,
    output logic      sck_fall_o
);

    pin_view_s now_q, prev_q;

    // Purpose: capture pins, then keep one older copy for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            now_q  <= '0;
            prev_q <= '0;
        end else begin
            now_q  <= '{cnv: cnv, sdi: sdi, sck: sck};
            prev_q <= now_q;
        end
    end

    // Purpose: expose views and single-cycle edge events.
    always_comb begin
        now_o      = now_q;
        prev_o     = prev_q;
        cnv_rise_o = now_q.cnv & ~prev_q.cnv;
        sck_fall_o = ~now_q.sck & prev_q.sck;
    end

endmodule

// File: rtl/sar_conv_ctrl.sv
// Module: conversion sequencer. Starts a conversion on a cnv rising edge
// while idle, latches port mode and the chain start-bit choice from the pin
// levels before that edge, and ends on conv_done, then picking the start bit.
// Assumes conv_done is a one-cycle pulse; pulses while idle are ignored.
module sar_conv_ctrl
    import sar_port_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  pin_view_s  now_i,
    input  pin_view_s  prev_i,
    input  logic       cnv_rise_i,
    input  logic       conv_done_i,
    output logic       converting_o,
    output port_mode_e mode_o,
    output logic       load_o,
    output logic       start_bit_o,
    output logic       abort_o
);

    logic       converting_q;
    port_mode_e mode_q;
    logic       chain_flag_q;
    logic       select_busy;

    // Purpose: track conversion state and latch the strap levels.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            converting_q <= 1'b0;
            mode_q       <= PORT_SELECT;
            chain_flag_q <= 1'b0;
        end else if (converting_q) begin
            if (conv_done_i) begin
                converting_q <= 1'b0;
            end
        end else if (cnv_rise_i) begin
            converting_q <= 1'b1;
            mode_q       <= prev_i.sdi ? PORT_SELECT : PORT_CHAIN;
            chain_flag_q <= prev_i.sck;
        end
    end

    // Purpose: decode load, abort and start-bit choice for the shifter.
    always_comb begin
        select_busy  = ~now_i.cnv | ~now_i.sdi;
        converting_o = converting_q;
        mode_o       = mode_q;
        load_o       = converting_q & conv_done_i;
        abort_o      = ~converting_q & cnv_rise_i;
        start_bit_o  = (mode_q == PORT_SELECT) ? select_busy : chain_flag_q;
    end

endmodule

// File: rtl/sar_shift_out.sv
// Module: result shifter. Holds an optional start bit and the result word,
// advances on sck falling edges, counts bits in select mode and recirculates
// sdi data behind the result in chain mode. Drives sdo with an enable.
// Assumes load and abort never coincide.
module sar_shift_out
    import sar_port_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic             abort_i,
    input  logic             start_bit_i,
    input  port_mode_e       mode_i,
    input  logic [RES_W-1:0] data_i,
    input  logic             sck_fall_i,
    input  logic             sdi_bit_i,
    input  logic             select_i,
    output logic             sdo_o,
    output logic             sdo_oe_o
);

    localparam int CNT_W = $clog2(RES_W + 1);

    logic [RES_W-1:0] shreg_q;
    logic [CNT_W-1:0] left_q;
    logic             active_q;
    logic             start_q;
    logic             enable;
    logic             chain;
    logic             shift_in;

    // Purpose: enable follows mode (chain always, select gated by select).
    always_comb begin
        chain    = (mode_i == PORT_CHAIN);
        enable   = active_q & (chain | select_i);
        shift_in = chain ? sdi_bit_i : 1'b0;
        sdo_oe_o = enable;
        sdo_o    = enable & (start_q | shreg_q[RES_W-1]);
    end

    // Purpose: load, abandon or advance the output sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            shreg_q  <= '0;
            left_q   <= '0;
            active_q <= 1'b0;
            start_q  <= 1'b0;
        end else if (load_i) begin
            shreg_q  <= data_i;
            left_q   <= CNT_W'(RES_W);
            active_q <= 1'b1;
            start_q  <= start_bit_i;
        end else if (abort_i) begin
            active_q <= 1'b0;
            start_q  <= 1'b0;
        end else if (enable && sck_fall_i) begin
            if (start_q) begin
                start_q <= 1'b0;
            end else begin
                shreg_q <= {shreg_q[RES_W-2:0], shift_in};
                if (!chain) begin
                    left_q <= left_q - 1'b1;
                    if (left_q == CNT_W'(1)) begin
                        active_q <= 1'b0;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/sar_serial_port.sv
// Module: top of the converter serial port. Connects pin sampling, the
// conversion sequencer and the result shifter.
// Assumes the core stub supplies conv_data valid with the conv_done pulse.
module sar_serial_port
    import sar_port_pkg::*;
#(
    parameter int RES_W = 18
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cnv,
    input  logic             sdi,
    input  logic             sck,
    input  logic             conv_done,
    input  logic [RES_W-1:0] conv_data,
    output logic             sdo,
    output logic             sdo_oe,
    output logic             conv_busy
);

    pin_view_s  now_v, prev_v;
    logic       cnv_rise, sck_fall;
    logic       load, abort, start_bit;
    port_mode_e mode;

    sar_pin_sampler u_pins (
        .clk        (clk),
        .rst_n      (rst_n),
        .cnv        (cnv),
        .sdi        (sdi),
        .sck        (sck),
        .now_o      (now_v),
        .prev_o     (prev_v),
        .cnv_rise_o (cnv_rise),
        .sck_fall_o (sck_fall)
    );

    sar_conv_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .now_i        (now_v),
        .prev_i       (prev_v),
        .cnv_rise_i   (cnv_rise),
        .conv_done_i  (conv_done),
        .converting_o (conv_busy),
        .mode_o       (mode),
        .load_o       (load),
        .start_bit_o  (start_bit),
        .abort_o      (abort)
    );

    sar_shift_out #(.RES_W(RES_W)) u_shift (
        .clk         (clk),
        .rst_n       (rst_n),
        .load_i      (load),
        .abort_i     (abort),
        .start_bit_i (start_bit),
        .mode_i      (mode),
        .data_i      (conv_data),
        .sck_fall_i  (sck_fall),
        .sdi_bit_i   (now_v.sdi),
        .select_i    (~now_v.cnv | ~now_v.sdi),
        .sdo_o       (sdo),
        .sdo_oe_o    (sdo_oe)
    );

endmodule

// File: rtl/sar_serial_port_checker.sv
// Module: port-level properties of the serial port, bound to the top.
module sar_serial_port_checker (
    input logic clk,
    input logic rst_n,
    input logic cnv,
    input logic conv_done,
    input logic sdo,
    input logic sdo_oe,
    input logic conv_busy
);

    // R10: nothing is driven while converting.
    p_quiet_in_conv_r10: assert property (@(posedge clk) disable iff (!rst_n)
        conv_busy |-> !sdo_oe);

    // R8: released output reads zero.
    p_released_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !sdo_oe |-> !sdo);

    // R2: a conversion only starts after cnv was seen high.
    p_start_needs_cnv_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(conv_busy) |-> $past(cnv));

    // R4: without conv_done a running conversion keeps running.
    p_conv_holds_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && !conv_done) |=> conv_busy);

    // R2: conv_done ends a running conversion.
    p_done_ends_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_busy && conv_done) |=> !conv_busy);

endmodule

bind sar_serial_port sar_serial_port_checker u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .cnv       (cnv),
    .conv_done (conv_done),
    .sdo       (sdo),
    .sdo_oe    (sdo_oe),
    .conv_busy (conv_busy)
);

// File: tb/sar_serial_port_bench.sv
module sar_serial_port_bench;

    localparam int W = 18;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         cnv = 1'b0, sdi = 1'b0, sck = 1'b0, conv_done = 1'b0;
    logic [W-1:0] conv_data = '0;
    logic         sdo, sdo_oe, conv_busy;

    int    n_tests = 0, n_fail = 0, cycles = 0;
    bit    finished = 0;
    string cur_req = "R1";

    always #10 clk = ~clk;

    sar_serial_port #(.RES_W(W)) u_sar_serial_port (
        .clk(clk), .rst_n(rst_n), .cnv(cnv), .sdi(sdi), .sck(sck),
        .conv_done(conv_done), .conv_data(conv_data),
        .sdo(sdo), .sdo_oe(sdo_oe), .conv_busy(conv_busy)
    );

    // Behavioural reference: pins are seen one clock late, edges two.
    bit m_conv, m_act, m_sel_mode, m_chain_flag, m_start;
    bit q[$];
    logic mq_cnv, mq_sdi, mq_sck, mp_cnv, mp_sdi, mp_sck;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_conv = 0; m_act = 0; m_sel_mode = 1; m_chain_flag = 0; m_start = 0;
            q.delete();
            {mq_cnv, mq_sdi, mq_sck, mp_cnv, mp_sdi, mp_sck} = '0;
        end else begin
            bit rise, fall, sel;
            rise = mq_cnv && !mp_cnv;
            fall = !mq_sck && mp_sck;
            sel  = !mq_cnv || !mq_sdi;
            if (m_conv) begin
                if (conv_done) begin
                    m_conv = 0; m_act = 1; q.delete();
                    for (int i = W-1; i >= 0; i--) q.push_back(conv_data[i]);
                    m_start = m_sel_mode ? sel : m_chain_flag;
                end
            end else if (rise) begin
                m_conv = 1; m_sel_mode = mp_sdi; m_chain_flag = mp_sck;
                m_act = 0; m_start = 0;
            end else if (m_act && fall && (!m_sel_mode || sel)) begin
                if (m_start) m_start = 0;
                else begin
                    void'(q.pop_front());
                    if (!m_sel_mode) q.push_back(mq_sdi);
                    else if (q.size() == 0) m_act = 0;
                end
            end
            mp_cnv = mq_cnv; mp_sdi = mq_sdi; mp_sck = mq_sck;
            mq_cnv = cnv; mq_sdi = sdi; mq_sck = sck;
        end
    end

    // Compare every clock, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            bit eoe, esdo;
            eoe  = m_act && (!m_sel_mode || !mq_cnv || !mq_sdi);
            esdo = eoe && (m_start || (q.size() > 0 && q[0]));
            n_tests++;
            if (sdo_oe !== eoe || sdo !== esdo || conv_busy !== m_conv) begin
                n_fail++;
                $display("FAIL %s: oe/sdo/busy actual %b%b%b expected %b%b%b at cycle %0d",
                         cur_req, sdo_oe, sdo, conv_busy, eoe, esdo, m_conv, cycles);
            end
        end
    end

    task automatic tick(int n = 1);
        repeat (n) @(negedge clk);
    endtask

    task automatic pulse_sck(int n, logic [31:0] din = '0);
        for (int i = 0; i < n; i++) begin
            sdi = din[i % 32];
            sck = 1'b1; tick(2);
            sck = 1'b0; tick(2);
        end
    endtask

    task automatic finish_conv(logic [W-1:0] d);
        tick(4);
        conv_data = d; conv_done = 1'b1; tick(1);
        conv_done = 1'b0; tick(2);
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1;
            $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected end before 150000", cycles);
            summary();
        end
    end

    initial begin
        tick(3);
        rst_n = 1'b1;
        tick(1);
        // R1: directed reset check
        n_tests++;
        if (sdo_oe !== 1'b0 || sdo !== 1'b0 || conv_busy !== 1'b0) begin
            n_fail++;
            $display("FAIL R1: actual %b%b%b expected 000", sdo_oe, sdo, conv_busy);
        end
        // R2: conv_done while idle ignored
        cur_req = "R2";
        conv_data = 18'h2B3C5; conv_done = 1'b1; tick(1); conv_done = 1'b0; tick(3);

        // R3 / R7 / R8: select mode, three-wire, no start bit
        cur_req = "R3"; sdi = 1'b1; tick(2);
        cnv = 1'b1; tick(3);
        cur_req = "R5"; finish_conv(18'h2B3C5);
        cur_req = "R8"; tick(2); cnv = 1'b0; tick(3);
        cur_req = "R7"; pulse_sck(10, 32'hFFFF_FFFF);
        cnv = 1'b1; tick(2); pulse_sck(3, 32'hFFFF_FFFF); cnv = 1'b0; tick(2);
        cur_req = "R8"; pulse_sck(10, 32'hFFFF_FFFF);

        // R5: select mode, cnv low before done gives a start bit
        cur_req = "R5"; cnv = 1'b1; tick(3); cnv = 1'b0; tick(2);
        finish_conv(18'h15A96);
        cur_req = "R7"; pulse_sck(20, 32'hFFFF_FFFF);

        // R5: four-wire, cnv held high, sdi low at done
        cur_req = "R5"; cnv = 1'b1; tick(3); sdi = 1'b0; tick(2);
        finish_conv(18'h30F0F);
        cur_req = "R8"; pulse_sck(5, 32'h0); sdi = 1'b1; tick(2);
        pulse_sck(4, 32'hFFFF_FFFF); sdi = 1'b0; tick(2);
        pulse_sck(16, 32'h0);
        cnv = 1'b0; tick(2);

        // R3: sdi tied to cnv gives chain mode; R9 pass-through
        cur_req = "R3"; sdi = 1'b1; tick(1); sdi = 1'b0; cnv = 1'b0; tick(3);
        cnv = 1'b1; sdi = 1'b1; tick(3);
        finish_conv(18'h0C3A5);
        cnv = 1'b0; sdi = 1'b0; tick(2);
        cur_req = "R9"; pulse_sck(30, 32'hA5C3_96E1);

        // R6: chain with sck high before cnv edge -> start bit
        cur_req = "R6"; sdi = 1'b0; sck = 1'b1; tick(3);
        cnv = 1'b1; tick(3); sck = 1'b0; tick(2);
        finish_conv(18'h3A5C3);
        cur_req = "R9"; pulse_sck(24, 32'h5A3C_0FF1);

        // R4: cnv re-edge during conversion ignored; R10 abort
        cur_req = "R4"; cnv = 1'b0; sdi = 1'b1; tick(3);
        cnv = 1'b1; tick(3); sdi = 1'b0; cnv = 1'b0; tick(3);
        cnv = 1'b1; tick(3); sdi = 1'b1;
        finish_conv(18'h1E1E1);
        cnv = 1'b0; tick(2);
        cur_req = "R10"; pulse_sck(6, 32'hFFFF_FFFF);
        cnv = 1'b1; tick(4); cnv = 1'b0; tick(4);
        pulse_sck(3, 32'hFFFF_FFFF);
        cnv = 1'b1; tick(3);
        finish_conv(18'h20001);
        cnv = 1'b0; tick(2);
        cur_req = "R7"; pulse_sck(20, 32'hFFFF_FFFF);
        tick(5);
        summary();
    end

endmodule